// File: doc/BRIEF.md
# Tick Timer with Match Modes

This block is a processor tick timer. A 32-bit count register advances by one on each tick. Ticks come from a divider that produces one enable pulse every `TICK_DIV` system clocks. With a 200 MHz system clock, the default of 10 gives a 20 MHz tick, which is one tick every 50 ns. A control register holds four things: a two-bit mode, an interrupt-enable bit, a sticky interrupt-pending bit and a 28-bit match period.

A match happens when an increment brings the low 28 bits of the count equal to the match period. The upper four count bits take no part in the compare. The mode then decides what happens on a match: the counter restarts from zero, stops for good, or keeps running. The disabled mode holds the counter still.

Software reaches both registers through a single-cycle register port. The port has a one-bit register select, a write strobe, write data and combinational read data. A level interrupt output shows a pending match whenever interrupts are enabled.

Top module: `tick_timer`

## Requirements
- R1: While reset is asserted and afterwards until the first write, the count reads 0, the control register reads 0, `irq_o` is 0 and the counter does not advance.
- R2: One tick occurs every `TICK_DIV` clocks. On each tick, while the counter is running, the count increases by exactly one and wraps modulo 2^32.
- R3: `reg_sel`=0 selects the count and `reg_sel`=1 selects the control register. The control register layout is: bits 31:30 the mode (00 off, 01 restart, 10 one-shot, 11 continuous), bit 29 the interrupt enable, bit 28 the pending flag, bits 27:0 the match period. Reads return the current values.
- R4: In mode 00 the count never advances and no match is signalled. A write of a non-zero mode starts the counter again.
- R5: A match happens on the tick whose increment makes count[27:0] equal to the period. Count bits 31:28 are ignored, so a period below the current field value is reached after the field wraps through zero.
- R6: In restart mode, the count becomes 0 on a match instead of the matching value.
- R7: In one-shot mode, the count takes the matching value on a match and then stops. A later control write with a non-zero mode starts it again from that value.
- R8: In continuous mode, the count takes the matching value on a match and keeps counting.
- R9: A match with the enable bit set sets the pending flag. The flag stays set until software writes 0 to bit 28. A clearing write in the same cycle as such a match leaves the flag set.
- R10: `irq_o` is high exactly when both the pending flag and the enable bit are 1.
- R11: A count write sets the count to the written value even in a cycle with an increment or a restart clear. The mode effects of a match in that cycle still apply.
- R12: A match while the enable bit is 0 leaves the pending flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 count, 1 control |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Level interrupt request |

## Verification
Several rules are checked by assertions on every clock cycle:
- the single-step increment and the hold when there is no advance;
- the restart clear and the one-shot stop;
- write priority on the count;
- the sticky pending flag, its set condition and the fact that a disabled interrupt never sets it;
- the spacing of the tick pulses.

Other behaviour only the bench scenarios can show. These include the field-only compare across a wrap of bits 27:0 and the ignored upper count bits. They also include restarting a stopped one-shot and the read-back layout of the control register. The last is the race between a software clear and a match in the same cycle, which random writes with small periods provoke against the bench's own model.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
package tick_timer_pkg;

  localparam int unsigned CNT_W   = 32;
  localparam int unsigned PER_W   = 28;
  localparam int unsigned MODE_HI = 31;
  localparam int unsigned MODE_LO = 30;
  localparam int unsigned IE_BIT  = 29;
  localparam int unsigned PEND_BIT = 28;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_RESTART = 2'b01,
    MODE_ONESHOT = 2'b10,
    MODE_CONT    = 2'b11
  } tmode_e;

  // Value the count takes on an advancing tick.
  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  // Compare only the low period field of a count with the match period.
  function automatic logic field_hit(input logic [CNT_W-1:0] c,
                                     input logic [PER_W-1:0] per);
    return c[PER_W-1:0] == per;
  endfunction

  // Assemble the readable control word.
  function automatic logic [CNT_W-1:0] pack_ctrl(input tmode_e m, input logic ie,
                                                 input logic pend,
                                                 input logic [PER_W-1:0] per);
    return {m, ie, pend, per};
  endfunction

endpackage

// File: rtl/tick_divider.sv
`timescale 1ns/1ps
module tick_divider #(
  parameter int unsigned TICK_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int unsigned PH_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam logic [PH_W-1:0] LAST_PH = PH_W'(TICK_DIV - 1);
      logic [PH_W-1:0] phase_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              phase_q <= '0;
        else if (phase_q == LAST_PH) phase_q <= '0;
        else                     phase_q <= phase_q + PH_W'(1);
      end

      assign tick_o = (phase_q == LAST_PH);

      // R2: ticks never come back to back when the divider is above one
      assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/tick_ctrl_reg.sv
`timescale 1ns/1ps
module tick_ctrl_reg
  import tick_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             hit_i,
  output tmode_e           mode_o,
  output logic             ie_o,
  output logic             pend_o,
  output logic [PER_W-1:0] period_o,
  output logic             run_o
);

  tmode_e           mode_q;
  logic             ie_q, pend_q, run_q;
  logic [PER_W-1:0] per_q;

  tmode_e wr_mode;
  logic   oneshot_stop;
  logic   pend_set;

  assign wr_mode      = tmode_e'(wdata_i[MODE_HI:MODE_LO]);
  assign oneshot_stop = hit_i && (mode_q == MODE_ONESHOT);
  assign pend_set     = hit_i && ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
      per_q  <= '0;
      run_q  <= 1'b0;
    end else begin
      if (wr_i) begin
        mode_q <= wr_mode;
        ie_q   <= wdata_i[IE_BIT];
        per_q  <= wdata_i[PER_W-1:0];
        run_q  <= (wr_mode != MODE_OFF);
      end else if (oneshot_stop) begin
        run_q  <= 1'b0;
      end
      pend_q <= (wr_i ? wdata_i[PEND_BIT] : pend_q) | pend_set;
    end
  end

  assign mode_o   = mode_q;
  assign ie_o     = ie_q;
  assign pend_o   = pend_q;
  assign period_o = per_q;
  assign run_o    = run_q;

  // R9: pending survives every cycle without a control write
  assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !wr_i |=> pend_q);
  // R9: an enabled match always leaves the flag set, even against a clear
  assert_pend_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i && ie_q |=> pend_q);
  // R12: with interrupts disabled, hardware never raises the flag
  assert_no_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i && !pend_q && !ie_q |=> !pend_q);
  // R7: a one-shot match stops the counter
  assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i && (mode_q == MODE_ONESHOT) && !wr_i |=> !run_q);

endmodule

// File: rtl/tick_count_reg.sv
`timescale 1ns/1ps
module tick_count_reg
  import tick_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance_i,
  input  tmode_e           mode_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic             hit_o
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] stepped;
  logic             restart_clr;

  assign stepped     = count_step(count_q);
  assign hit_o       = advance_i && field_hit(stepped, period_i);
  assign restart_clr = hit_o && (mode_i == MODE_RESTART);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           count_q <= '0;
    else if (wr_i)        count_q <= wdata_i;
    else if (restart_clr) count_q <= '0;
    else if (advance_i)   count_q <= stepped;
  end

  assign count_o = count_q;

  // R2: a plain advance moves the count by exactly one
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    advance_i && !wr_i && !(hit_o && mode_i == MODE_RESTART)
      |=> count_q == $past(count_q) + 32'd1);
  // R6: restart mode returns the count to zero on a match
  assert_restart_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o && (mode_i == MODE_RESTART) && !wr_i |=> count_q == '0);
  // R4: without an advance or a write the count holds
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !advance_i && !wr_i |=> $stable(count_q));
  // R11: a software write always lands
  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> count_q == $past(wdata_i));

endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned TICK_DIV = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_o
);

  logic             tick;
  logic             running;
  logic             advance;
  logic             match_hit;
  logic             cnt_wr, ctl_wr;
  tmode_e           mode;
  logic             ie, pend;
  logic [PER_W-1:0] period;
  logic [CNT_W-1:0] count;

  assign cnt_wr  = reg_we && !reg_sel;
  assign ctl_wr  = reg_we &&  reg_sel;
  assign advance = tick && running;

  tick_divider #(.TICK_DIV(TICK_DIV)) div_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  tick_count_reg cnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance_i (advance),
    .mode_i    (mode),
    .period_i  (period),
    .wr_i      (cnt_wr),
    .wdata_i   (reg_wdata),
    .count_o   (count),
    .hit_o     (match_hit)
  );

  tick_ctrl_reg ctl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (ctl_wr),
    .wdata_i  (reg_wdata),
    .hit_i    (match_hit),
    .mode_o   (mode),
    .ie_o     (ie),
    .pend_o   (pend),
    .period_o (period),
    .run_o    (running)
  );

  assign reg_rdata = reg_sel ? pack_ctrl(mode, ie, pend, period) : count;
  assign irq_o     = pend && ie;

  // R4: the off mode never produces a match
  assert_off_no_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |-> !match_hit);
  // R1: the first cycle after reset leaves the counter idle
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (count == '0 || $past(cnt_wr)) && !irq_o);

endmodule

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb_top;

  localparam int unsigned DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int unsigned total = 0;
  int unsigned bad = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  tick_timer #(.TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  // Reference model restated from the requirements
  logic [31:0] m_cnt, m_ctl;
  logic        m_run;
  int unsigned m_ph;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= '0; m_ctl <= '0; m_run <= 1'b0; m_ph <= 0;
    end else begin : model
      bit tk, adv, hit;
      logic [31:0] nxt;
      logic pend_next;
      tk  = (m_ph == DIV - 1);
      m_ph <= tk ? 0 : m_ph + 1;
      adv = tk && m_run;
      nxt = m_cnt + 32'd1;
      hit = adv && (nxt[27:0] == m_ctl[27:0]);
      if (reg_we && !reg_sel)                  m_cnt <= reg_wdata;
      else if (hit && m_ctl[31:30] == 2'b01)   m_cnt <= '0;
      else if (adv)                            m_cnt <= nxt;
      pend_next = (reg_we && reg_sel) ? reg_wdata[28] : m_ctl[28];
      if (hit && m_ctl[29]) pend_next = 1'b1;
      if (reg_we && reg_sel) begin
        m_ctl <= {reg_wdata[31:29], pend_next, reg_wdata[27:0]};
        m_run <= (reg_wdata[31:30] != 2'b00);
      end else begin
        m_ctl[28] <= pend_next;
        if (hit && m_ctl[31:30] == 2'b10) m_run <= 1'b0;
      end
    end
  end

  function automatic logic [31:0] ctl(input logic [1:0] m, input logic ie,
                                      input logic pd, input logic [27:0] per);
    return {m, ie, pd, per};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    reg_sel = sel;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] v, held;

  initial begin
    void'($urandom(32'd1234));
    wait_cyc(3);
    rd(0, v); check("R1 count in reset", v, 32'h0);
    rst_n = 1'b1;
    wait_cyc(1);
    rd(0, v); check("R1 count after reset", v, 32'h0);
    rd(1, v); check("R1 control after reset", v, 32'h0);
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);

    wait_cyc(20);
    rd(0, v); check("R4 off mode holds zero", v, 32'h0);
    wr(0, 32'd7); wait_cyc(12);
    rd(0, v); check("R4 off mode holds written", v, 32'd7);

    wr(1, ctl(2'b11, 1'b0, 1'b0, 28'h0FFFFFF));
    rd(1, v); check("R3 control readback", v, ctl(2'b11, 1'b0, 1'b0, 28'h0FFFFFF));

    wr(0, 32'd100); wait_cyc(10 * DIV);
    rd(0, v); check("R2 ten ticks", v, 32'd110);

    wr(1, ctl(2'b11, 1'b1, 1'b0, 28'd5));
    wr(0, 32'hF000_0002); wait_cyc(2 * DIV);
    rd(1, v); check("R5 no match before field", {31'b0, v[28]}, 32'h0);
    wait_cyc(DIV);
    rd(0, v); check("R5 upper bits ignored count", v, 32'hF000_0005);
    rd(1, v); check("R5 match sets pending", {31'b0, v[28]}, 32'h1);
    check("R10 irq on pending", {31'b0, irq_o}, 32'h1);
    wait_cyc(3 * DIV);
    rd(1, v); check("R9 pending sticky", {31'b0, v[28]}, 32'h1);

    wr(1, ctl(2'b11, 1'b0, 1'b1, 28'd5));
    rd(1, v); check("R10 pending kept, ie off", {31'b0, v[28]}, 32'h1);
    check("R10 irq masked", {31'b0, irq_o}, 32'h0);
    wr(1, ctl(2'b11, 1'b1, 1'b0, 28'h0FFFFFF));
    rd(1, v); check("R9 software clear", {31'b0, v[28]}, 32'h0);
    check("R10 irq after clear", {31'b0, irq_o}, 32'h0);

    wr(1, ctl(2'b11, 1'b1, 1'b0, 28'd1));
    wr(0, 32'h0FFF_FFFE); wait_cyc(2 * DIV);
    rd(0, v); check("R5 field wraps", v, 32'h1000_0000);
    rd(1, v); check("R5 no match at wrap", {31'b0, v[28]}, 32'h0);
    wait_cyc(DIV);
    rd(1, v); check("R5 match after wrap", {31'b0, v[28]}, 32'h1);

    wr(1, ctl(2'b01, 1'b0, 1'b0, 28'd3));
    wr(0, 32'd0); wait_cyc(3 * DIV);
    rd(0, v); check("R6 restart to zero", v, 32'd0);
    rd(1, v); check("R12 no pending without ie", {31'b0, v[28]}, 32'h0);
    check("R12 irq low", {31'b0, irq_o}, 32'h0);
    wait_cyc(DIV);
    rd(0, v); check("R6 counting after restart", v, 32'd1);

    wr(1, ctl(2'b10, 1'b0, 1'b0, 28'd4));
    wr(0, 32'd0); wait_cyc(10 * DIV);
    rd(0, v); check("R7 one-shot stops at match", v, 32'd4);
    wr(1, ctl(2'b10, 1'b0, 1'b0, 28'd4)); wait_cyc(2 * DIV - 1);
    rd(0, v); check("R7 rewrite restarts", v, 32'd6);

    wr(1, ctl(2'b11, 1'b1, 1'b0, 28'd2));
    wr(0, 32'd0); wait_cyc(5 * DIV);
    rd(0, v); check("R8 continuous runs past match", v, 32'd5);
    rd(1, v); check("R8 continuous match pending", {31'b0, v[28]}, 32'h1);

    wr(1, ctl(2'b01, 1'b0, 1'b0, 28'd2));
    @(negedge clk); reg_sel = 1'b0; reg_we = 1'b1; reg_wdata = 32'd1;
    wait_cyc(3 * DIV); reg_we = 1'b0;
    rd(0, v); check("R11 write beats restart clear", v, 32'd1);
    wr(1, ctl(2'b11, 1'b0, 1'b0, 28'h0FFFFFF));
    @(negedge clk); reg_sel = 1'b0; reg_we = 1'b1; reg_wdata = 32'd50;
    wait_cyc(3 * DIV); reg_we = 1'b0;
    rd(0, v); check("R11 write beats increment", v, 32'd50);

    wr(1, 32'h0);
    rd(0, held); wait_cyc(5 * DIV);
    rd(0, v); check("R4 off mode stops counter", v, held);

    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      @(negedge clk);
      rd(0, v); check("R2 model count", v, m_cnt);
      rd(1, v); check("R3 model control", v, m_ctl);
      check("R10 model irq", {31'b0, irq_o}, {31'b0, m_ctl[28] & m_ctl[29]});
      r = $urandom_range(0, 99);
      if (r < 25) begin
        reg_sel = 1'b1; reg_we = 1'b1;
        reg_wdata = ctl(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                        1'($urandom_range(0, 1)), 28'($urandom_range(0, 7)));
      end else if (r < 40) begin
        reg_sel = 1'b0; reg_we = 1'b1;
        reg_wdata = (r < 33) ? 32'($urandom_range(0, 7)) : $urandom;
      end else begin
        reg_we = 1'b0;
      end
    end
    @(negedge clk); reg_we = 1'b0;
    rd(0, v); check("R9 final model count", v, m_cnt);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule